// File: doc/BRIEF.md
# Carrier Loop Filter with Phase Accumulator

This block is the control core of a carrier recovery loop that runs at the symbol rate. Once per symbol strobe it takes a signed phase-error sample. A proportional-integral filter turns the sample into a phase step, and the step advances a 32-bit phase accumulator that wraps once per full carrier cycle. The phase word goes to a sine/cosine generator and a derotator, which lie outside this block. The integrator state, which is the loop's running estimate of the carrier frequency offset, is also exported as a frequency word.

The two gains are runtime registers. A write is accepted only when the stability ordering between the gains holds. The integrator is watched for abrupt per-update jumps that point to a cycle slip. When a slip is seen, the block raises a one-cycle request and can optionally zero its own integrator.

The controls take effect in this priority order: clear, then freeze, then the symbol strobe. Clear zeroes the loop state, freeze suspends updates, and the strobe applies one update.

Top module: `carrier_loop_nco`

## Requirements
- R1: After reset the phase word, frequency word, slip request and gain-error bit are all zero. The gains start at Kp = 1127 (Q0.16, about 0.0172) and Ki = 2466 (Q0.24, about 1.47e-4).
- R2: The loop state changes only on a clock edge where the symbol strobe is high. Without a strobe the phase and frequency words hold their values.
- R3: The integrator is 40 bits wide with 4 fraction bits below the phase unit. On each strobe it adds err*Ki/16 rounded, and the frequency word is integrator bits [35:4].
- R4: On each strobe the phase word advances, modulo 2^32, by the updated frequency word plus err*Kp (Kp taken as an integer 0..65535).
- R5: The phase error is signed 16-bit two's complement, with -32768..32767 covering -pi..pi. One error LSB is 2^16 phase units, and pi is 2^31 phase units.
- R6: A gain write loads Kp and Ki together when Ki < Kp*256, which is the check Ki < Kp after aligning the two fractions.
- R7: A gain write with Ki >= Kp*256 leaves both gains unchanged and sets the gain-error bit. That bit stays set until reset, even through later valid writes.
- R8: Clear zeroes the integrator and the phase word on the next edge. It overrides freeze and strobe and leaves the gains unchanged.
- R9: While freeze is high, strobes are ignored and both the phase and frequency words keep their values.
- R10: A strobe whose integrator step magnitude exceeds the slip limit (in phase units; default 2^31, that is pi) raises the slip request for exactly the following cycle.
- R11: On a slip with slip reset enabled, the integrator is zeroed instead of updated, and the phase word advances only by err*Kp.
- R12: The Ki product is rounded half up. A raw product whose remainder is exactly 8/16 rounds toward plus infinity, so err*Ki = 8 steps by +1 and err*Ki = -8 steps by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One loop update per high cycle |
| phase_err | input | 16 | Signed phase error, full scale = ±pi |
| freeze | input | 1 | Suspend updates, keep state |
| clear | input | 1 | Zero integrator and phase |
| slip_reset_en | input | 1 | Zero integrator when a slip is detected |
| gain_wr | input | 1 | Gain write strobe |
| kp_in | input | 16 | Proportional gain, unsigned Q0.16 |
| ki_in | input | 24 | Integral gain, unsigned Q0.24 |
| nco_phase | output | 32 | Phase accumulator, 2^32 = one cycle |
| freq_word | output | 32 | Integrator in phase units per symbol |
| slip_flag | output | 1 | One-cycle slip / re-acquire request |
| gain_err | output | 1 | Sticky rejected-gain-write flag |

## Verification
Assertions check, on every cycle, the properties that hold for every kind of update. Clear zeroes the state. The state holds when no effective strobe is present. A rejected gain write freezes the gains and sets the sticky bit. The stored gains always satisfy the stability ordering. A slip request follows only an update, and a slip with reset enabled zeroes the integrator. Only the bench scenarios can show that the arithmetic is right: the rounding at the half boundary, the sign handling across the full error range, the modulo wrap of the phase, the exact slip threshold, and the use of the old gains after a rejected write. These scenarios compare the ports against a model computed in wide integers.

// File: rtl/carrier_pkg.sv
package carrier_pkg;

    localparam int ERR_W_D  = 16;
    localparam int KP_W_D   = 16;
    localparam int KI_W_D   = 24;
    localparam int PH_W_D   = 32;
    localparam int FRAC_W_D = 4;
    localparam int INT_W_D  = 40;

    localparam logic [KP_W_D-1:0] KP_NOMINAL = 16'd1127;
    localparam logic [KI_W_D-1:0] KI_NOMINAL = 24'd2466;

    // What one clock edge does to the loop state
    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_CLEAR,
        UPD_STEP,
        UPD_SLIP_ZERO
    } upd_kind_t;

    typedef struct packed {
        logic [KP_W_D-1:0] kp;
        logic [KI_W_D-1:0] ki;
    } gain_pair_t;

    // Ki (Q0.24) must stay below Kp (Q0.16) once the fractions are aligned
    function automatic logic gain_order_ok(input logic [KP_W_D-1:0] kp,
                                           input logic [KI_W_D-1:0] ki);
        return ki < {kp, {(KI_W_D-KP_W_D){1'b0}}};
    endfunction

endpackage

// File: rtl/cpl_gain_regs.sv
module cpl_gain_regs
    import carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gain_wr,
    input  logic [KP_W_D-1:0] kp_in,
    input  logic [KI_W_D-1:0] ki_in,
    output gain_pair_t        gains,
    output logic              gain_err
);

    logic accept;
    assign accept = gain_order_ok(kp_in, ki_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            gains.kp <= KP_NOMINAL;
            gains.ki <= KI_NOMINAL;
            gain_err <= 1'b0;
        end else if (gain_wr) begin
            if (accept) begin
                gains.kp <= kp_in;
                gains.ki <= ki_in;
            end else begin
                gain_err <= 1'b1;
            end
        end
    end

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_wr && !accept) |=> ($stable(gains) && gain_err));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        gain_err |=> gain_err);

    // R6
    gain_order_chk: assert property (@(posedge clk) disable iff (rst)
        gains.ki < {gains.kp, {(KI_W_D-KP_W_D){1'b0}}});

endmodule

// File: rtl/cpl_loop_filter.sv
module cpl_loop_filter
    import carrier_pkg::*;
#(
    parameter int          ERR_W    = ERR_W_D,
    parameter int          KI_W     = KI_W_D,
    parameter int          PH_W     = PH_W_D,
    parameter int          FRAC_W   = FRAC_W_D,
    parameter int          INT_W    = INT_W_D,
    parameter int unsigned SLIP_LIM = 32'h8000_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    advance,
    input  logic                    slip_reset_en,
    input  logic signed [ERR_W-1:0] err,
    input  logic [KI_W-1:0]         ki,
    output logic [PH_W-1:0]         freq_step,
    output logic [PH_W-1:0]         freq_word,
    output logic                    slip_flag
);

    localparam int PROD_W = ERR_W + KI_W + 1;
    localparam int STEP_W = PROD_W - FRAC_W;
    localparam logic [STEP_W-1:0] SLIP_THR = STEP_W'(SLIP_LIM) << FRAC_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [STEP_W-1:0] step;
    logic        [STEP_W-1:0] step_mag;
    logic signed [INT_W-1:0]  integ_q;
    logic signed [INT_W-1:0]  integ_sum;
    logic                     slip_det;
    upd_kind_t                kind;

    assign prod = err * $signed({1'b0, ki});

    generate
        if (FRAC_W > 0) begin : g_round
            localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);
            logic signed [PROD_W-1:0] rnd;
            assign rnd  = prod + HALF;
            assign step = STEP_W'(rnd >>> FRAC_W);
        end else begin : g_exact
            assign step = prod;
        end
    endgenerate

    assign step_mag  = step[STEP_W-1] ? STEP_W'(-step) : STEP_W'(step);
    assign slip_det  = advance && (step_mag > SLIP_THR);
    assign integ_sum = integ_q + INT_W'(step);

    always_comb begin
        if (clear)                        kind = UPD_CLEAR;
        else if (!advance)                kind = UPD_HOLD;
        else if (slip_det && slip_reset_en) kind = UPD_SLIP_ZERO;
        else                              kind = UPD_STEP;
    end

    assign freq_step = (kind == UPD_SLIP_ZERO) ? '0 : integ_sum[FRAC_W +: PH_W];
    assign freq_word = integ_q[FRAC_W +: PH_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q   <= '0;
            slip_flag <= 1'b0;
        end else begin
            unique case (kind)
                UPD_CLEAR:     integ_q <= '0;
                UPD_SLIP_ZERO: integ_q <= '0;
                UPD_STEP:      integ_q <= integ_sum;
                default:       integ_q <= integ_q;
            endcase
            slip_flag <= slip_det && !clear;
        end
    end

    // R8
    integ_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (integ_q == '0));

    // R2
    integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(integ_q));

    // R11
    slip_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && slip_det && slip_reset_en) |=> (integ_q == '0));

    // R10
    slip_origin_chk: assert property (@(posedge clk) disable iff (rst)
        slip_flag |-> ($past(advance) && !$past(clear)));

endmodule

// File: rtl/cpl_nco.sv
module cpl_nco
    import carrier_pkg::*;
#(
    parameter int ERR_W = ERR_W_D,
    parameter int KP_W  = KP_W_D,
    parameter int PH_W  = PH_W_D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    advance,
    input  logic signed [ERR_W-1:0] err,
    input  logic [KP_W-1:0]         kp,
    input  logic [PH_W-1:0]         freq_step,
    output logic [PH_W-1:0]         phase
);

    logic [PH_W-1:0] prop;

    assign prop = PH_W'(err * $signed({1'b0, kp}));

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase <= '0;
        else if (advance)
            phase <= phase + freq_step + prop;
    end

    // R8
    phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (phase == '0));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(phase));

endmodule

// File: rtl/carrier_loop_nco.sv
module carrier_loop_nco
    import carrier_pkg::*;
#(
    parameter int          ERR_W    = ERR_W_D,
    parameter int          KP_W     = KP_W_D,
    parameter int          KI_W     = KI_W_D,
    parameter int          PH_W     = PH_W_D,
    parameter int          FRAC_W   = FRAC_W_D,
    parameter int          INT_W    = INT_W_D,
    parameter int unsigned SLIP_LIM = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_stb,
    input  logic [ERR_W-1:0] phase_err,
    input  logic             freeze,
    input  logic             clear,
    input  logic             slip_reset_en,
    input  logic             gain_wr,
    input  logic [KP_W-1:0]  kp_in,
    input  logic [KI_W-1:0]  ki_in,
    output logic [PH_W-1:0]  nco_phase,
    output logic [PH_W-1:0]  freq_word,
    output logic             slip_flag,
    output logic             gain_err
);

    gain_pair_t               gains;
    logic                     advance;
    logic signed [ERR_W-1:0]  err_s;
    logic [PH_W-1:0]          freq_step;

    assign advance = sym_stb && !freeze;
    assign err_s   = $signed(phase_err);

    cpl_gain_regs gains_i (
        .clk      (clk),
        .rst      (rst),
        .gain_wr  (gain_wr),
        .kp_in    (kp_in),
        .ki_in    (ki_in),
        .gains    (gains),
        .gain_err (gain_err)
    );

    cpl_loop_filter #(
        .ERR_W    (ERR_W),
        .KI_W     (KI_W),
        .PH_W     (PH_W),
        .FRAC_W   (FRAC_W),
        .INT_W    (INT_W),
        .SLIP_LIM (SLIP_LIM)
    ) filt_i (
        .clk           (clk),
        .rst           (rst),
        .clear         (clear),
        .advance       (advance),
        .slip_reset_en (slip_reset_en),
        .err           (err_s),
        .ki            (gains.ki),
        .freq_step     (freq_step),
        .freq_word     (freq_word),
        .slip_flag     (slip_flag)
    );

    cpl_nco #(
        .ERR_W (ERR_W),
        .KP_W  (KP_W),
        .PH_W  (PH_W)
    ) nco_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .advance   (advance),
        .err       (err_s),
        .kp        (gains.kp),
        .freq_step (freq_step),
        .phase     (nco_phase)
    );

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear) |=> ($stable(nco_phase) && $stable(freq_word)));

endmodule

// File: tb/carrier_loop_nco_tb_top.sv
`timescale 1ns/1ps
module carrier_loop_nco_tb_top;

    localparam int unsigned SLIP_LIM_TB = 32'h0010_0000;
    localparam longint      MASK32      = 64'h0000_0000_FFFF_FFFF;
    localparam longint      THR_INT     = longint'(SLIP_LIM_TB) <<< 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_stb = 1'b0;
    logic [15:0] phase_err = '0;
    logic        freeze = 1'b0;
    logic        clear = 1'b0;
    logic        slip_reset_en = 1'b0;
    logic        gain_wr = 1'b0;
    logic [15:0] kp_in = '0;
    logic [23:0] ki_in = '0;
    logic [31:0] nco_phase;
    logic [31:0] freq_word;
    logic        slip_flag;
    logic        gain_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    longint m_integ = 0;
    longint m_phase = 0;
    longint m_kp = 1127;
    longint m_ki = 2466;
    bit     m_slip = 1'b0;
    bit     m_gerr = 1'b0;

    always #2.5 clk = ~clk;

    carrier_loop_nco #(.SLIP_LIM(SLIP_LIM_TB)) dut_i (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .phase_err(phase_err),
        .freeze(freeze), .clear(clear), .slip_reset_en(slip_reset_en),
        .gain_wr(gain_wr), .kp_in(kp_in), .ki_in(ki_in),
        .nco_phase(nco_phase), .freq_word(freq_word),
        .slip_flag(slip_flag), .gain_err(gain_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "phase", longint'(nco_phase), m_phase);
        chk(req, "freq", longint'(freq_word), (m_integ >>> 4) & MASK32);
        chk(req, "slip", longint'(slip_flag), longint'(m_slip));
        chk(req, "gain_err", longint'(gain_err), longint'(m_gerr));
    endtask

    task automatic model_step(input int e);
        longint prod, stp, mag;
        prod = longint'(e) * m_ki;
        stp  = (prod + 8) >>> 4;
        mag  = (stp < 0) ? -stp : stp;
        m_slip = (mag > THR_INT);
        if (m_slip && slip_reset_en)
            m_integ = 0;
        else begin
            m_integ = m_integ + stp;
            m_integ = (m_integ <<< 24) >>> 24;
        end
        m_phase = (m_phase + ((m_integ >>> 4) & MASK32) + longint'(e) * m_kp) & MASK32;
    endtask

    task automatic strobe(input int e, input string req);
        @(negedge clk);
        sym_stb   = 1'b1;
        phase_err = 16'(e);
        @(negedge clk);
        sym_stb = 1'b0;
        model_step(e);
        chk_all(req);
        m_slip = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_all(req);
        end
    endtask

    task automatic write_gains(input int kp, input int ki, input string req);
        @(negedge clk);
        gain_wr = 1'b1;
        kp_in   = 16'(kp);
        ki_in   = 24'(ki);
        @(negedge clk);
        gain_wr = 1'b0;
        if (longint'(ki) < longint'(kp) * 256) begin
            m_kp = kp;
            m_ki = ki;
        end else
            m_gerr = 1'b1;
        chk(req, "gain_err", longint'(gain_err), longint'(m_gerr));
    endtask

    task automatic do_clear(input bit with_freeze, input bit with_stb);
        @(negedge clk);
        clear     = 1'b1;
        freeze    = with_freeze;
        sym_stb   = with_stb;
        phase_err = 16'd12345;
        @(negedge clk);
        clear = 1'b0; freeze = 1'b0; sym_stb = 1'b0;
        m_integ = 0;
        m_phase = 0;
        m_slip  = 1'b0;
        chk_all("R8");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_all("R1");

        // R1 nominal gains, R3 R4 first update
        strobe(1000, "R1");
        strobe(-2500, "R3");
        // R2 no strobe -> hold
        idle(5, "R2");

        // R12 rounding at the half boundary
        do_clear(1'b0, 1'b0);
        write_gains(1127, 8, "R6");
        for (int i = 0; i < 16; i++) strobe(1, "R12");
        chk("R12", "freq_pos_half", longint'(freq_word), 1);
        for (int i = 0; i < 16; i++) strobe(-1, "R12");
        chk("R12", "freq_neg_half", longint'(freq_word), 1);
        write_gains(1127, 9, "R6");
        for (int i = 0; i < 32; i++) strobe(-1, "R12");
        chk("R12", "freq_neg_round", longint'(freq_word), 64'hFFFF_FFFF);
        write_gains(1127, 7, "R6");
        strobe(1, "R12");

        // R3 R4 R5 sweeps over the full signed error range
        for (int g = 0; g < 3; g++) begin
            do_clear(1'b0, 1'b0);
            case (g)
                0: write_gains(1127, 2466, "R6");
                1: write_gains(65535, 40000, "R6");
                default: write_gains(300, 512, "R6");
            endcase
            for (int e = -32768; e <= 32767; e += 1171) strobe(e, "R4");
            strobe(32767, "R5");
            strobe(-32768, "R5");
        end

        // R6 boundary accept, R7 boundary reject
        write_gains(10, 2560, "R7");
        strobe(20000, "R7");
        write_gains(10, 2559, "R6");
        strobe(20000, "R6");
        write_gains(200, 50000, "R7");
        strobe(-15000, "R7");
        write_gains(1127, 2466, "R7");
        strobe(777, "R7");

        // R9 freeze ignores strobes
        @(negedge clk);
        freeze = 1'b1; sym_stb = 1'b1; phase_err = 16'd5000;
        repeat (3) @(negedge clk);
        chk_all("R9");
        freeze = 1'b0; sym_stb = 1'b0;
        idle(1, "R9");

        // R8 clear beats freeze and strobe, gains kept
        do_clear(1'b1, 1'b1);
        strobe(4321, "R8");
        do_clear(1'b0, 1'b1);
        strobe(-321, "R8");

        // R10 slip detection without reset
        write_gains(100, 16384, "R6");
        slip_reset_en = 1'b0;
        strobe(1000, "R10");
        @(negedge clk);
        sym_stb = 1'b1; phase_err = 16'd32767;
        @(negedge clk);
        sym_stb = 1'b0;
        model_step(32767);
        chk("R10", "slip_expected", longint'(m_slip), 1);
        chk_all("R10");
        m_slip = 1'b0;
        idle(1, "R10");
        strobe(-1000, "R10");

        // R11 slip with integrator reset
        slip_reset_en = 1'b1;
        @(negedge clk);
        sym_stb = 1'b1; phase_err = 16'h8000;
        @(negedge clk);
        sym_stb = 1'b0;
        model_step(-32768);
        chk_all("R11");
        chk("R11", "freq_zero", longint'(freq_word), 0);
        m_slip = 1'b0;
        idle(1, "R11");
        strobe(500, "R11");
        slip_reset_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule